// File: doc/BRIEF.md
# Programmable Chip-Select Decoder

This block turns a 16-bit bus address into select strobes for external program memory, a general-purpose memory region and two I/O pages. One 8-bit control register sets it up. Software writes that register through a simple write port and can read it back at any time. The register chooses the size of the program window. It also chooses which of two overlapping selects wins, and whether each I/O select is in use and with which polarity. The general-purpose region is supplied from outside as a base address and a power-of-two size. Each I/O page is a fixed 256-byte window set by a parameter.

Every select is computed from the address, the bus-valid strobe and the register contents of one cycle, then registered. The selects therefore appear one clock later. When an I/O select is disabled, its pin is reported as free for general use.

The design has no state machine. Its only state is the control register and the output flops.

Top module: `chipsel_ctrl`

## Requirements
- R1: The control register is laid out, MSB first, as: io0 enable (bit 7), io0 polarity (bit 6), io1 enable (bit 5), io1 polarity (bit 4), general-select priority (bit 3), program-select enable (bit 2), and the size code (bits 1:0, bit 1 being the upper code bit). A write with `reg_we_i` high replaces the register at the clock edge, and `reg_rdata_o` always shows the current value.
- R2: A clock edge with `rst_n` low (synchronous reset) clears every register bit except the program-select enable, which takes the value of `exp_mode_i`. It also drives `cs_prog_o` and `cs_gen_o` to 0 and both `cs_io_o` bits to 1.
- R3: The size code k (0 to 3) makes the program window the top 64 KB / 2^k of the address space. Code 0 covers 0x0000–0xFFFF, code 1 covers 0x8000–0xFFFF, code 2 covers 0xC000–0xFFFF and code 3 covers 0xE000–0xFFFF.
- R4: `cs_prog_o` (active high) can only assert when the program-select enable is 1, `bus_valid_i` is 1 and the address is inside the program window.
- R5: `cs_gen_o` (active high) asserts when `bus_valid_i` is 1 and the address is inside the general window. When the program and general selects both match, priority bit 0 keeps the program select and drops the general one, and priority bit 1 does the reverse. The two are never high together.
- R6: The general window covers the addresses whose bits above bit `gen_log2_i` equal those of `gen_base_i`. Its size is 2^`gen_log2_i` bytes, and a value of 16 covers the whole space.
- R7: I/O select n matches when `bus_valid_i` is 1 and address bits 15:8 equal its page (0x40 for io0, 0x41 for io1). When enabled, the output is the match (polarity 1) or its inverse (polarity 0). When disabled, it sits at its inactive level, which is 0 for polarity 1 and 1 for polarity 0, and `io_free_o[n]` is 1.
- R8: Every select output reflects the address, strobe and register value of the previous clock cycle. A register write affects the selects from the cycle after the write.
- R9: Writing 0x05 gives an enabled 32 KB program window at 0x8000–0xFFFF with program priority, and both I/O pins free and held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exp_mode_i | input | 1 | Expanded-bus mode, sampled while in reset |
| bus_addr_i | input | 16 | Bus address |
| bus_valid_i | input | 1 | Address strobe qualifier |
| reg_we_i | input | 1 | Control register write enable |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read-back |
| gen_base_i | input | 16 | General window base address |
| gen_log2_i | input | 5 | log2 of the general window size (0..16) |
| cs_prog_o | output | 1 | Program memory select, active high |
| cs_gen_o | output | 1 | General-purpose select, active high |
| cs_io_o | output | 2 | I/O selects, polarity set by the register |
| io_free_o | output | 2 | I/O pin free for general use |

## Verification
The embedded assertions check several properties on every cycle:
- a write lands in the register one edge later;
- the program and general selects never assert together;
- a cycle without the strobe, or with the program select disabled, produces no memory select;
- an address below a 32 KB window never selects program memory;
- a disabled active-low I/O pin stays high.

The bench's scenarios cover the rest:
- the exact shape of each size window at its edges;
- the reset value that depends on the mode input;
- which select wins an overlap under each priority setting;
- general windows of different sizes;
- polarity inversion on enabled I/O pages.

// File: rtl/chipsel_pkg.sv
package chipsel_pkg;

    localparam int CFG_W     = 8;
    localparam int SIZE_W    = 2;
    localparam int NUM_SIZES = 1 << SIZE_W;
    localparam int NUM_IO    = 2;

    typedef struct packed {
        logic              io0_en;
        logic              io0_pol;
        logic              io1_en;
        logic              io1_pol;
        logic              gen_first;
        logic              prog_en;
        logic [SIZE_W-1:0] prog_size;
    } csel_cfg_t;

endpackage

// File: rtl/csel_cfg_reg.sv
module csel_cfg_reg
    import chipsel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exp_mode,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output csel_cfg_t        cfg,
    output logic [CFG_W-1:0] rdata
);

    csel_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q         <= '0;
            cfg_q.prog_en <= exp_mode;
        end else if (we) begin
            cfg_q <= csel_cfg_t'(wdata);
        end
    end

    assign cfg   = cfg_q;
    assign rdata = CFG_W'(cfg_q);

    // R1: a write is visible on the read port after one edge
    p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rdata == $past(wdata)));

    // R1: without a write the register holds
    p_reg_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && $past(rst_n)) |=> $stable(rdata));

endmodule

// File: rtl/csel_win_match.sv
module csel_win_match
    import chipsel_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LOG_W  = $clog2(ADDR_W + 1)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size_code,
    input  logic [ADDR_W-1:0] gen_base,
    input  logic [LOG_W-1:0]  gen_log2,
    output logic              prog_hit,
    output logic              gen_hit
);

    logic [NUM_SIZES-1:0] top_ones;

    generate
        for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
            if (k == 0) begin : g_full
                assign top_ones[k] = 1'b1;
            end else begin : g_part
                assign top_ones[k] = &addr[ADDR_W-1 -: k];
            end
        end
    endgenerate

    assign prog_hit = top_ones[size_code];

    logic [ADDR_W:0] addr_hi;
    logic [ADDR_W:0] base_hi;

    always_comb begin
        addr_hi = {1'b0, addr}     >> gen_log2;
        base_hi = {1'b0, gen_base} >> gen_log2;
        gen_hit = (addr_hi == base_hi);
    end

endmodule

// File: rtl/csel_io_port.sv
module csel_io_port #(
    parameter int          PAGE_W = 8,
    parameter logic [PAGE_W-1:0] PAGE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAGE_W-1:0] addr_page,
    input  logic              valid,
    input  logic              en,
    input  logic              pol,
    output logic              cs,
    output logic              free
);

    logic hit;
    logic cs_d;

    always_comb begin
        hit = valid && (addr_page == PAGE);
        if (en) cs_d = pol ? hit : ~hit;
        else    cs_d = ~pol;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cs <= 1'b1;
        else        cs <= cs_d;
    end

    assign free = ~en;

    // R7: disabled active-low pin stays high
    p_idle_low_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !pol) |=> cs);

    // R7: enabled active-high pin stays low with no strobe
    p_no_strobe_io_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pol && !valid) |=> !cs);

endmodule

// File: rtl/chipsel_ctrl.sv
module chipsel_ctrl
    import chipsel_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int PAGE_W  = 8,
    parameter logic [NUM_IO*PAGE_W-1:0] IO_PAGES = {8'h41, 8'h40},
    localparam int LOG_W  = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exp_mode_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_valid_i,
    input  logic              reg_we_i,
    input  logic [CFG_W-1:0]  reg_wdata_i,
    output logic [CFG_W-1:0]  reg_rdata_o,
    input  logic [ADDR_W-1:0] gen_base_i,
    input  logic [LOG_W-1:0]  gen_log2_i,
    output logic              cs_prog_o,
    output logic              cs_gen_o,
    output logic [NUM_IO-1:0] cs_io_o,
    output logic [NUM_IO-1:0] io_free_o
);

    csel_cfg_t cfg;
    logic      prog_win;
    logic      gen_win;

    csel_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .exp_mode (exp_mode_i),
        .we       (reg_we_i),
        .wdata    (reg_wdata_i),
        .cfg      (cfg),
        .rdata    (reg_rdata_o)
    );

    csel_win_match #(.ADDR_W(ADDR_W), .LOG_W(LOG_W)) u_win (
        .addr      (bus_addr_i),
        .size_code (cfg.prog_size),
        .gen_base  (gen_base_i),
        .gen_log2  (gen_log2_i),
        .prog_hit  (prog_win),
        .gen_hit   (gen_win)
    );

    logic p_raw, g_raw, prog_d, gen_d;

    always_comb begin
        p_raw  = cfg.prog_en && bus_valid_i && prog_win;
        g_raw  = bus_valid_i && gen_win;
        prog_d = p_raw && !(g_raw && cfg.gen_first);
        gen_d  = g_raw && !(p_raw && !cfg.gen_first);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prog_o <= 1'b0;
            cs_gen_o  <= 1'b0;
        end else begin
            cs_prog_o <= prog_d;
            cs_gen_o  <= gen_d;
        end
    end

    logic [NUM_IO-1:0] io_en;
    logic [NUM_IO-1:0] io_pol;
    assign io_en  = {cfg.io1_en,  cfg.io0_en};
    assign io_pol = {cfg.io1_pol, cfg.io0_pol};

    generate
        for (genvar i = 0; i < NUM_IO; i++) begin : g_io
            csel_io_port #(
                .PAGE_W (PAGE_W),
                .PAGE   (IO_PAGES[i*PAGE_W +: PAGE_W])
            ) u_io (
                .clk       (clk),
                .rst_n     (rst_n),
                .addr_page (bus_addr_i[ADDR_W-1 -: PAGE_W]),
                .valid     (bus_valid_i),
                .en        (io_en[i]),
                .pol       (io_pol[i]),
                .cs        (cs_io_o[i]),
                .free      (io_free_o[i])
            );
        end
    endgenerate

    // R5: the two memory selects are exclusive
    p_mem_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs_prog_o && cs_gen_o));

    // R4: no strobe, no memory select
    p_no_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid_i |=> (!cs_prog_o && !cs_gen_o));

    // R4: program select disabled keeps it low
    p_prog_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.prog_en |=> !cs_prog_o);

    // R3: a 32 KB window excludes the lower half
    p_half_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.prog_size == 2'b01 && !bus_addr_i[ADDR_W-1]) |=> !cs_prog_o);

endmodule

// File: tb/sim_chipsel_ctrl.sv
module sim_chipsel_ctrl;

    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exp_mode_i = 1'b0;
    logic [15:0] bus_addr_i = '0;
    logic        bus_valid_i = 1'b0;
    logic        reg_we_i = 1'b0;
    logic [7:0]  reg_wdata_i = '0;
    logic [7:0]  reg_rdata_o;
    logic [15:0] gen_base_i = 16'h2000;
    logic [4:0]  gen_log2_i = 5'd12;
    logic        cs_prog_o, cs_gen_o;
    logic [1:0]  cs_io_o, io_free_o;

    always #HALF clk = ~clk;

    chipsel_ctrl u0 (.*);

    int tests = 0;
    int fails = 0;
    logic [7:0] m_reg;
    logic       e_prog, e_gen;
    logic [1:0] e_io;
    logic [31:0] lfsr = 32'hACE1_2468;

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit prog_win(input logic [15:0] a, input int k);
        if (k == 0) return 1'b1;
        return ((int'(a) >> (16 - k)) == ((1 << k) - 1));
    endfunction

    // Reference model, evaluated once per edge
    task automatic tick();
        bit ph, gh, praw, graw, hit, en, pol;
        @(posedge clk);
        #1;
        if (!rst_n) begin
            m_reg  = exp_mode_i ? 8'h04 : 8'h00;
            e_prog = 0; e_gen = 0; e_io = 2'b11;
        end else begin
            ph   = prog_win(bus_addr_i, int'(m_reg[1:0]));
            gh   = ((int'(bus_addr_i) >> gen_log2_i) == (int'(gen_base_i) >> gen_log2_i));
            praw = m_reg[2] && bus_valid_i && ph;
            graw = bus_valid_i && gh;
            e_prog = praw && !(graw && m_reg[3]);
            e_gen  = graw && !(praw && !m_reg[3]);
            for (int i = 0; i < 2; i++) begin
                en  = m_reg[7 - 2*i];
                pol = m_reg[6 - 2*i];
                hit = bus_valid_i && (bus_addr_i[15:8] == (8'h40 + 8'(i)));
                e_io[i] = en ? (pol ? hit : !hit) : !pol;
            end
            if (reg_we_i) m_reg = reg_wdata_i;
        end
        chk("R1 rdata",           reg_rdata_o, m_reg);
        chk("R3/R4/R5/R8 cs_prog", cs_prog_o,  e_prog);
        chk("R5/R6/R8 cs_gen",     cs_gen_o,   e_gen);
        chk("R7/R8 cs_io",         cs_io_o,    e_io);
        chk("R7 io_free",          io_free_o,  {~m_reg[5], ~m_reg[7]});
    endtask

    task automatic wr(input logic [7:0] v);
        reg_we_i = 1; reg_wdata_i = v; bus_valid_i = 0;
        tick();
        reg_we_i = 0;
    endtask

    task automatic bus(input logic [15:0] a, input logic v);
        bus_addr_i = a; bus_valid_i = v;
        tick();
    endtask

    initial begin
        #(HALF * 2 * 190000);
        fails++;
        $display("FAIL watchdog all-requirements act=hung exp=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R2: reset with single-chip mode
        exp_mode_i = 0;
        repeat (3) tick();
        chk("R2 reset reg", reg_rdata_o, 8'h00);
        chk("R2 reset io", cs_io_o, 2'b11);
        // R2: reset with expanded mode sets program enable
        exp_mode_i = 1;
        repeat (2) tick();
        chk("R2 expanded reset", reg_rdata_o, 8'h04);
        rst_n = 1; exp_mode_i = 0;
        bus(16'h0000, 1); bus(16'hFFFF, 1); bus(16'h1234, 0);

        // R9: typical setup value
        wr(8'h05);
        chk("R9 value", reg_rdata_o, 8'h05);
        bus(16'h7FFF, 1);
        chk("R9 below window", cs_prog_o, 0);
        bus(16'h8000, 1);
        chk("R9 window start", cs_prog_o, 1);
        chk("R9 pins free", io_free_o, 2'b11);

        // R3: each size code at its edges
        for (int k = 0; k < 4; k++) begin
            logic [15:0] lo;
            lo = 16'(17'h10000 - (17'h10000 >> k));
            wr(8'h04 | 8'(k));
            bus(lo, 1);
            chk("R3 window low edge", cs_prog_o, 1);
            if (k != 0) begin
                bus(lo - 16'd1, 1);
                chk("R3 just below window", cs_prog_o, 0);
            end
        end

        // R5/R6: overlap, program priority then general priority
        gen_base_i = 16'hE000; gen_log2_i = 5'd12;
        wr(8'h07);
        bus(16'hE800, 1);
        chk("R5 prog wins", {cs_prog_o, cs_gen_o}, 2'b10);
        wr(8'h0F);
        bus(16'hE800, 1);
        chk("R5 gen wins", {cs_prog_o, cs_gen_o}, 2'b01);
        bus(16'hF000, 1);
        chk("R6 outside gen window", {cs_prog_o, cs_gen_o}, 2'b10);
        gen_log2_i = 5'd16;
        bus(16'h0100, 1);
        chk("R6 whole-space window", cs_gen_o, 1);

        // R7: I/O polarity and enable combinations
        wr(8'hE0);
        bus(16'h4010, 1);
        chk("R7 io0 active high", cs_io_o[0], 1);
        bus(16'h4110, 1);
        chk("R7 io1 active low", cs_io_o[1], 0);
        wr(8'h50);
        bus(16'h4010, 1);
        chk("R7 disabled high-pol idle", cs_io_o, 2'b00);
        chk("R7 free flags", io_free_o, 2'b11);

        // R8: write in same cycle as access uses the old value
        reg_we_i = 1; reg_wdata_i = 8'h04; bus_addr_i = 16'h9000; bus_valid_i = 1;
        tick();
        reg_we_i = 0;
        chk("R8 old value used", cs_prog_o, 0);
        bus(16'h9000, 1);
        chk("R8 new value used", cs_prog_o, 1);

        // Mixed traffic, model compared every cycle
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (lfsr[2:0] == 0) begin
                wr(lfsr[15:8]);
            end else begin
                gen_log2_i = (lfsr[20:16] > 5'd16) ? 5'd8 : lfsr[20:16];
                if (lfsr[26]) gen_base_i = {lfsr[31:27], 11'h0};
                bus(lfsr[3] ? {lfsr[10:9] == 0 ? 8'h40 : 8'h41, lfsr[18:11]}
                            : {lfsr[31:24], lfsr[15:8]}, lfsr[4] | lfsr[5]);
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule